// File: doc/BRIEF.md
# Timer/Counter Channel with Compare Outputs

This block is one waveform-mode timer channel for use inside a larger timer unit. An up-counter runs from one of several count sources. Four of them are divided taps of the system clock. The other two are external inputs: a slow reference clock and a chain input, which can be fed from a neighbouring channel's waveform output to build a wider counter.

Two compare registers watch the counter. A match on the A compare raises the waveform output and a match on the C compare lowers it. The C compare can also wrap the counter and can optionally stop the channel, which gives a one-shot delay. Software drives the block through a small word-addressed register port. A control word starts, stops and restarts the count. A status word holds sticky event flags that clear when the word is read. An interrupt mask is written through separate set and clear addresses. A block-wide sync input zeroes the counter so that several channels can be aligned.

Register addresses: 0 control (write), 1 mode, 2 counter (read), 3 compare A, 4 compare C, 5 status (read clears), 6 mask set, 7 mask clear. Reads at addresses 6 and 7 both return the mask.

Top module: `tc_channel`

## Requirements
- R1: After a synchronous active-low reset, the counter, both compare values, the mode word, the status flags, the mask, `wave_out` and `irq` are all zero, and the channel is stopped.
- R2: With mode bit 4 clear (free-run), every count tick adds one to the counter. On a tick where the counter holds its all-ones value it wraps to zero and sets status bit 0 (wrap flag).
- R3: With mode bit 4 set (up-to-C), a tick where the counter equals compare C loads zero instead of adding one. Any tick where the counter equals compare C sets status bit 2, and a tick where it equals compare A sets status bit 1.
- R4: With mode bit 5 set (stop-on-C), a compare-C tick stops the channel. Status bit 8 (running) then reads 0 and the counter holds its value.
- R5: Control write bit 0 starts the channel and bit 1 stops it; when both are set, stop wins. Bit 2 zeroes the counter in that cycle, with no compare event. While the channel is stopped, the counter does not change.
- R6: Reading status returns the flags and then clears them. A flag event in the same cycle as the read stays set afterwards.
- R7: A write to address 6 ORs the low data byte into the 8-bit mask, and a write to address 7 clears the mask bits that are 1 in the data. `irq` is high while any of status bits 2..0 is set with the same mask bit set.
- R8: `wave_out` goes to 1 on a compare-A tick and to 0 on a compare-C tick. When both match on the same tick, it goes to 0.
- R9: Mode bits 2..0 select the tick source. Values 0..3 tick once every 2, 8, 32 and 128 clocks. Value 4 selects a rising edge of `slow_clk_in` and value 5 a rising edge of `chain_in`; each edge advances the counter at the third clock edge after the input is first sampled high. Values 6 and 7 never tick.
- R10: `blk_sync` zeroes the counter at the next clock edge and takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status at address 5) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| slow_clk_in | input | 1 | Slow reference clock, sampled and edge-detected |
| chain_in | input | 1 | Chain clock from another channel, sampled and edge-detected |
| blk_sync | input | 1 | Block-wide counter zeroing pulse |
| wave_out | output | 1 | Compare-driven waveform output |
| irq | output | 1 | Masked event interrupt |

## Verification
A wrong count or a wrong running state shows up first in `wave_out`, which toggles at the compare points, and in `irq`, once the sticky flags are unmasked. Both outputs are compared on every clock, so a divergence is seen within one tick period of the bad event. The counter and flags are also read back many times per scenario. Phase-shifted status reads check that an event landing on the read cycle survives it, which a design that clears too eagerly would lose only occasionally.

// File: rtl/tc_pkg.sv
// Shared definitions for the timer channel: register addresses, bit positions
// of the control and mode words, and the per-tick event bundle.
package tc_pkg;

    typedef enum logic [2:0] {
        ADR_CTRL  = 3'd0,
        ADR_MODE  = 3'd1,
        ADR_COUNT = 3'd2,
        ADR_CMPA  = 3'd3,
        ADR_CMPC  = 3'd4,
        ADR_STAT  = 3'd5,
        ADR_MSET  = 3'd6,
        ADR_MCLR  = 3'd7
    } tc_addr_e;

    localparam int CTL_START = 0;
    localparam int CTL_STOP  = 1;
    localparam int CTL_TRIG  = 2;

    localparam int MOD_SEL_LSB = 0;
    localparam int MOD_UPTO_C  = 4;
    localparam int MOD_STOP_C  = 5;

    localparam int STAT_RUN_BIT = 8;
    localparam int NUM_FLAGS    = 3;
    localparam int MASK_W       = 8;

    typedef struct packed {
        logic cmp_c;
        logic cmp_a;
        logic wrap;
    } tc_evt_t;

endpackage

// File: rtl/tc_tick_gen.sv
// Count-source selector. Assumes sel is stable for a tick period; a free
// prescaler provides the divided taps, and two external inputs are passed
// through a two-flop synchroniser and a rising-edge detector.
module tc_tick_gen #(
    parameter int TAP_BASE = 1,
    parameter int TAP_STEP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       slow_in,
    input  logic       chain_in,
    output logic       tick
);
    localparam int NUM_TAPS = 4;
    localparam int PRE_W    = TAP_BASE + TAP_STEP * (NUM_TAPS - 1);
    localparam int NUM_EXT  = 2;

    logic [PRE_W-1:0]    pre_q;
    logic [NUM_TAPS-1:0] tap_tick;
    logic [NUM_EXT-1:0]  ext_in;
    logic [NUM_EXT-1:0]  ext_tick;

    assign ext_in = {chain_in, slow_in};

    // Free-running prescaler shared by all divided taps.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int LG = TAP_BASE + TAP_STEP * g;
        assign tap_tick[g] = &pre_q[LG-1:0];
    end

    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
        logic [2:0] sh_q;
        // Synchronise the external clock and keep one older sample for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[1:0], ext_in[e]};
        end
        assign ext_tick[e] = sh_q[1] & ~sh_q[2];
    end

    // Pick the tick of the selected source.
    always_comb begin
        tick = 1'b0;
        if (!sel[2])           tick = tap_tick[sel[1:0]];
        else if (sel == 3'd4)  tick = ext_tick[0];
        else if (sel == 3'd5)  tick = ext_tick[1];
    end

endmodule

// File: rtl/tc_count_core.sv
// Counter, run state, compare logic and waveform output. Assumes the caller
// supplies one-cycle tick pulses; a zeroing request (sync or trigger)
// overrides any tick in the same cycle and produces no events.
module tc_count_core
    import tc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctl_wr,
    input  logic             ctl_start,
    input  logic             ctl_stop,
    input  logic             ctl_trig,
    input  logic             sync,
    input  logic             upto_c,
    input  logic             stop_c,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_c,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             wave,
    output tc_evt_t          evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             wave_q;
    logic             zero_now;
    logic             adv;
    logic             hit_a;
    logic             hit_c;

    assign zero_now = sync | (ctl_wr & ctl_trig);
    assign adv      = run_q & tick & ~zero_now;
    assign hit_a    = adv & (cnt_q == cmp_a);
    assign hit_c    = adv & (cnt_q == cmp_c);

    assign evt.cmp_c = hit_c;
    assign evt.cmp_a = hit_a;
    assign evt.wrap  = adv & (cnt_q == CNT_MAX) & ~(upto_c & hit_c);

    // Counter: zero on request, otherwise step or fold back at compare C.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (zero_now)      cnt_q <= '0;
        else if (adv) begin
            if (upto_c && hit_c) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
        end
    end

    // Run state: software stop beats start; compare C may halt in one-shot mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                  run_q <= 1'b0;
        else if (ctl_wr && ctl_stop)  run_q <= 1'b0;
        else if (ctl_wr && ctl_start) run_q <= 1'b1;
        else if (hit_c && stop_c)     run_q <= 1'b0;
    end

    // Waveform: rise on compare A, fall on compare C, fall wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)     wave_q <= 1'b0;
        else if (hit_c) wave_q <= 1'b0;
        else if (hit_a) wave_q <= 1'b1;
    end

    assign cnt     = cnt_q;
    assign running = run_q;
    assign wave    = wave_q;

endmodule

// File: rtl/tc_status.sv
// Sticky event flags with clear-on-read and the interrupt mask. Assumes
// a set and a clear of the mask never happen in the same cycle; a new event
// in the read cycle survives the clear.
module tc_status
    import tc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  tc_evt_t           evt,
    input  logic              stat_rd,
    input  logic              mask_set,
    input  logic              mask_clr,
    input  logic [MASK_W-1:0] wbyte,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [MASK_W-1:0] mask,
    output logic              irq
);
    logic [NUM_FLAGS-1:0] flags_q;
    logic [MASK_W-1:0]    mask_q;

    // Flags: drop on read, then merge this cycle's events.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (stat_rd ? '0 : flags_q) | evt;
    end

    // Mask: write-one-to-set and write-one-to-clear views.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '0;
        else if (mask_set) mask_q <= mask_q | wbyte;
        else if (mask_clr) mask_q <= mask_q & ~wbyte;
    end

    assign irq   = |(flags_q & mask_q[NUM_FLAGS-1:0]);
    assign flags = flags_q;
    assign mask  = mask_q;

endmodule

// File: rtl/tc_channel.sv
// Top of one timer channel: register decode, mode and compare registers,
// and read multiplexer around the tick generator, counter core and status.
// Assumes at most one of bus_wr / bus_rd per cycle; reads are combinational.
module tc_channel
    import tc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              slow_clk_in,
    input  logic              chain_in,
    input  logic              blk_sync,
    output logic              wave_out,
    output logic              irq
);
    logic [2:0]           sel_q;
    logic                 upto_q;
    logic                 stopc_q;
    logic [CNT_W-1:0]     cmpa_q;
    logic [CNT_W-1:0]     cmpc_q;
    logic                 tick;
    logic [CNT_W-1:0]     cnt_v;
    logic                 running;
    tc_evt_t              evt;
    logic [NUM_FLAGS-1:0] flags;
    logic [MASK_W-1:0]    mask;
    logic                 wr_ctl;
    logic                 wr_mode;
    logic                 wr_a;
    logic                 wr_c;

    assign wr_ctl  = bus_wr && (bus_addr == ADR_CTRL);
    assign wr_mode = bus_wr && (bus_addr == ADR_MODE);
    assign wr_a    = bus_wr && (bus_addr == ADR_CMPA);
    assign wr_c    = bus_wr && (bus_addr == ADR_CMPC);

    // Mode and compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            upto_q  <= 1'b0;
            stopc_q <= 1'b0;
            cmpa_q  <= '0;
            cmpc_q  <= '0;
        end else begin
            if (wr_mode) begin
                sel_q   <= bus_wdata[MOD_SEL_LSB +: 3];
                upto_q  <= bus_wdata[MOD_UPTO_C];
                stopc_q <= bus_wdata[MOD_STOP_C];
            end
            if (wr_a) cmpa_q <= bus_wdata[CNT_W-1:0];
            if (wr_c) cmpc_q <= bus_wdata[CNT_W-1:0];
        end
    end

    tc_tick_gen u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel_q),
        .slow_in  (slow_clk_in),
        .chain_in (chain_in),
        .tick     (tick)
    );

    tc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ctl_wr    (wr_ctl),
        .ctl_start (bus_wdata[CTL_START]),
        .ctl_stop  (bus_wdata[CTL_STOP]),
        .ctl_trig  (bus_wdata[CTL_TRIG]),
        .sync      (blk_sync),
        .upto_c    (upto_q),
        .stop_c    (stopc_q),
        .cmp_a     (cmpa_q),
        .cmp_c     (cmpc_q),
        .cnt       (cnt_v),
        .running   (running),
        .wave      (wave_out),
        .evt       (evt)
    );

    tc_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .stat_rd  (bus_rd && (bus_addr == ADR_STAT)),
        .mask_set (bus_wr && (bus_addr == ADR_MSET)),
        .mask_clr (bus_wr && (bus_addr == ADR_MCLR)),
        .wbyte    (bus_wdata[MASK_W-1:0]),
        .flags    (flags),
        .mask     (mask),
        .irq      (irq)
    );

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_MODE: begin
                bus_rdata[MOD_SEL_LSB +: 3] = sel_q;
                bus_rdata[MOD_UPTO_C]       = upto_q;
                bus_rdata[MOD_STOP_C]       = stopc_q;
            end
            ADR_COUNT: bus_rdata[CNT_W-1:0] = cnt_v;
            ADR_CMPA:  bus_rdata[CNT_W-1:0] = cmpa_q;
            ADR_CMPC:  bus_rdata[CNT_W-1:0] = cmpc_q;
            ADR_STAT: begin
                bus_rdata[NUM_FLAGS-1:0] = flags;
                bus_rdata[STAT_RUN_BIT]  = running;
            end
            ADR_MSET, ADR_MCLR: bus_rdata[MASK_W-1:0] = mask;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tc_channel_chk.sv
// Protocol checker for tc_channel, attached by bind. Watches the register
// port, the sync input and the counter and run state of the core.
module tc_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             blk_sync,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic             running,
    input logic [7:0]       mask
);
    // R10
    sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_sync |=> (cnt == '0));

    // R5
    trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && bus_wdata[2]) |=> (cnt == '0));

    // R5
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && bus_wdata[1]) |=> !running);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !bus_wr && !blk_sync) |=> $stable(cnt));

    // R2
    step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0));

    // R7
    mask_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd7 && bus_wdata[7:0] == 8'hFF) |=> (mask == 8'h00 && !irq));

endmodule

bind tc_channel tc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .blk_sync  (blk_sync),
    .irq       (irq),
    .cnt       (cnt_v),
    .running   (running),
    .mask      (mask)
);

// File: tb/tb_tc_channel.sv
`timescale 1ns/1ps
module tb_tc_channel;
    localparam int W = 8;
    localparam int CMAX = (1 << W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        slow_clk_in = 1'b0, chain_in = 1'b0, blk_sync = 1'b0;
    logic        wave_out, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit live = 0;

    always #2.5 clk = ~clk;

    tc_channel #(.CNT_W(W)) dut (.*);

    // Behavioural reference state.
    int m_cnt, m_run, m_wave, m_flags, m_mask, m_sel, m_upto, m_stopc, m_a, m_c, m_pre;
    int s1, s2, s3, c1, c2, c3;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_run = 0; m_wave = 0; m_flags = 0; m_mask = 0;
            m_sel = 0; m_upto = 0; m_stopc = 0; m_a = 0; m_c = 0; m_pre = 0;
            s1 = 0; s2 = 0; s3 = 0; c1 = 0; c2 = 0; c3 = 0;
        end else begin
            int tk, lg, ctl, zero, adv, ha, hc, ov;
            tk = 0;
            if (m_sel < 4) begin
                lg = 1 + 2 * m_sel;
                tk = ((m_pre % (1 << lg)) == (1 << lg) - 1);
            end else if (m_sel == 4) tk = s2 && !s3;
            else if (m_sel == 5) tk = c2 && !c3;
            m_pre = (m_pre + 1) % 128;
            s3 = s2; s2 = s1; s1 = slow_clk_in;
            c3 = c2; c2 = c1; c1 = chain_in;
            ctl  = bus_wr && bus_addr == 0;
            zero = blk_sync || (ctl && bus_wdata[2]);
            adv  = m_run && tk && !zero;
            ha   = adv && m_cnt == m_a;
            hc   = adv && m_cnt == m_c;
            ov   = adv && m_cnt == CMAX && !(m_upto && hc);
            if (bus_rd && bus_addr == 5) m_flags = 0;
            m_flags = m_flags | (hc << 2) | (ha << 1) | ov;
            if (zero) m_cnt = 0;
            else if (adv) m_cnt = (m_upto && hc) ? 0 : (m_cnt + 1) % (CMAX + 1);
            if (hc) m_wave = 0; else if (ha) m_wave = 1;
            if (ctl && bus_wdata[1]) m_run = 0;
            else if (ctl && bus_wdata[0]) m_run = 1;
            else if (hc && m_stopc) m_run = 0;
            if (bus_wr && bus_addr == 1) begin
                m_sel = bus_wdata[2:0]; m_upto = bus_wdata[4]; m_stopc = bus_wdata[5];
            end
            if (bus_wr && bus_addr == 3) m_a = bus_wdata[W-1:0];
            if (bus_wr && bus_addr == 4) m_c = bus_wdata[W-1:0];
            if (bus_wr && bus_addr == 6) m_mask = m_mask | bus_wdata[7:0];
            if (bus_wr && bus_addr == 7) m_mask = m_mask & ~bus_wdata[7:0];
        end
    end

    function automatic int exp_read(input int a);
        case (a)
            1: return m_sel | (m_upto << 4) | (m_stopc << 5);
            2: return m_cnt;
            3: return m_a;
            4: return m_c;
            5: return m_flags | (m_run << 8);
            6, 7: return m_mask;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison of the outputs against the model.
    always @(negedge clk) begin
        if (live) begin
            chk("R8 wave_out", int'(wave_out), m_wave);
            chk("R7 irq", int'(irq), ((m_flags & m_mask & 7) != 0) ? 1 : 0);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 3'(a);
        #1;
        chk(tag, int'(bus_rdata), exp_read(a));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_ext(input bit which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (which) chain_in = 1'b1; else slow_clk_in = 1'b1;
            idle(3);
            if (which) chain_in = 1'b0; else slow_clk_in = 1'b0;
            idle(3);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        live = 1;
        // R1: reset state
        chk("R1 count", int'(dut.bus_rdata), 0);
        rd(2, "R1 count");
        rd(5, "R1 status");
        rd(6, "R1 mask");
        rd(1, "R1 mode");
        chk("R1 wave", int'(wave_out), 0);

        // R2 / R8: free-run, /2 tap, waveform between A and C
        wr(6, 8'h07);
        rd(7, "R7 mask set");
        wr(3, 8'h10);
        wr(4, 8'h80);
        wr(1, 0);
        wr(0, 5);
        for (int i = 0; i < 12; i++) begin
            idle(45);
            rd(2, "R2 free-run count");
        end
        rd(5, "R2 wrap flag");
        rd(5, "R6 cleared after read");

        // R3: up-to-C on /8 tap
        wr(4, 5);
        wr(3, 2);
        wr(1, 32'h11);
        wr(0, 4);
        for (int i = 0; i < 8; i++) begin
            idle(13);
            rd(2, "R3 fold count");
        end
        rd(5, "R3 compare flags");

        // R6: reads at shifting phases against frequent compare events
        wr(4, 1);
        wr(1, 32'h10);
        for (int i = 0; i < 12; i++) begin
            idle(i % 3);
            rd(5, "R6 read vs event");
        end

        // R4: one-shot stop at C
        wr(4, 20);
        wr(1, 32'h30);
        wr(0, 5);
        idle(10);
        rd(5, "R4 still running");
        idle(60);
        rd(5, "R4 stopped");
        rd(2, "R4 held count");
        idle(20);
        rd(2, "R4 held count later");

        // R5: start and stop together, stop wins; trigger while stopped
        wr(1, 0);
        wr(0, 1);
        idle(30);
        wr(0, 3);
        rd(5, "R5 stop wins");
        rd(2, "R5 stopped count");
        idle(25);
        rd(2, "R5 count frozen");
        wr(0, 4);
        rd(2, "R5 trigger zero");

        // R9: taps 2 and 3, external sources, dead selections
        wr(1, 2);
        wr(0, 5);
        idle(100);
        rd(2, "R9 tap /32");
        wr(1, 3);
        wr(0, 4);
        idle(300);
        rd(2, "R9 tap /128");
        wr(1, 4);
        wr(0, 4);
        pulse_ext(1'b0, 5);
        rd(2, "R9 slow edges");
        pulse_ext(1'b1, 3);
        rd(2, "R9 chain ignored under slow");
        wr(1, 5);
        pulse_ext(1'b1, 4);
        rd(2, "R9 chain edges");
        wr(1, 6);
        idle(40);
        rd(2, "R9 dead selection");

        // R10: block sync zeroes a running counter
        wr(1, 0);
        idle(37);
        @(negedge clk); blk_sync = 1'b1;
        @(negedge clk); blk_sync = 1'b0;
        bus_addr = 3'd2; #1;
        chk("R10 sync zero", int'(bus_rdata), exp_read(2));
        chk("R10 sync zero abs", int'(bus_rdata) <= 1 ? 0 : 1, 0);
        idle(9);
        rd(2, "R10 counting after sync");

        // R7: disable all sources
        rd(5, "R7 flags before mask clear");
        wr(7, 8'hFF);
        rd(6, "R7 mask cleared");
        idle(50);
        chk("R7 irq masked", int'(irq), 0);

        live = 0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule